// File: doc/BRIEF.md
# Wiper Position Register with Tap Decoder

This block holds the current position of a digitally controlled potentiometer wiper and turns it into the enable vector for the tap switches of a resistor chain. The position is a small unsigned code; the decoder raises exactly one switch enable, so the wiper always touches one tap. Code zero selects the tap at the low terminal and the all-ones code selects the tap at the high terminal.

The position can be changed from four sources. A serial command can write a new value directly. A transfer command can copy one entry of a bank of stored registers into it. In stepping mode, the command interface sends strobes that move the wiper one tap up or down, and the steps stop at either end. A recall strobe, raised after power-up, copies stored entry zero into the position. When more than one source is active in a cycle, a fixed priority picks one. The position is also driven out for readback and for copying into the stored bank.

The enable vector is registered at the same edge as the position. Because of this, the decoder never shows an intermediate code while the position changes.

Top module: `wiper_tap_ctrl`

## Requirements
- R1: While rst_n is low at a rising clock edge, the position becomes 0 and tap_en becomes 64'h1.
- R2: tap_en always has exactly one bit set, and that bit is the one whose index equals pos. Bit 0 is the low-terminal tap and bit 63 is the high-terminal tap.
- R3: wr_en high at an edge loads wr_val into pos and updates tap_en at that same edge.
- R4: xfer_en high at an edge loads stored entry xfer_sel from reg_bank. Entry i sits in bits [6i+5:6i].
- R5: step_en with step_up=1 raises pos by one at that edge.
- R6: step_en with step_up=0 lowers pos by one at that edge.
- R7: A step up at 63 and a step down at 0 leave pos and tap_en unchanged.
- R8: recall high at an edge loads entry 0 of reg_bank. It overrides any other source active in the same cycle.
- R9: Without recall, the sources rank as follows: wr_en first, then xfer_en, then step_en. Only the highest-ranked active source changes pos.
- R10: With no source active, pos and tap_en hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recall | input | 1 | Power-up recall strobe, loads entry 0 |
| wr_en | input | 1 | Direct write strobe |
| wr_val | input | 6 | Value for direct write |
| xfer_en | input | 1 | Transfer strobe from stored bank |
| xfer_sel | input | 2 | Index of stored entry to transfer |
| step_en | input | 1 | Single step strobe |
| step_up | input | 1 | Step direction, 1 toward high end |
| reg_bank | input | 24 | Four stored 6-bit entries, flattened |
| pos | output | 6 | Current wiper position |
| tap_en | output | 64 | One-hot tap switch enables |

## Verification
The recall strobe and a bus command can arrive in the same cycle. The bench provokes this by raising recall together with a write, and separately together with a transfer and a step. The result counts as correct only if pos equals stored entry zero and not the command's value. Collisions among the bus sources alone are checked the same way: a write paired with a step, and a transfer paired with a step. Each is judged against the ranked source's result.

// File: rtl/wiper_pkg.sv
// Package: shared widths and source selection type for the wiper block.
// Assumes a power-of-two tap count derived from the position width.
package wiper_pkg;
    localparam int POS_W    = 6;
    localparam int NUM_REGS = 4;
    localparam int SEL_W    = $clog2(NUM_REGS);
    localparam int TAPS     = 1 << POS_W;

    typedef enum logic [2:0] {
        SRC_NONE   = 3'd0,
        SRC_RECALL = 3'd1,
        SRC_WRITE  = 3'd2,
        SRC_XFER   = 3'd3,
        SRC_STEP   = 3'd4
    } src_e;
endpackage

// File: rtl/wiper_stepper.sv
// Saturating one-step adder/subtractor for the wiper position.
// Assumes an unsigned position; it holds at both ends instead of wrapping.
module wiper_stepper #(
    parameter int W = 6
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Compute the neighbour tap, clamped at the ends of the chain.
    always_comb begin
        if (up) nxt = (cur == TOP) ? cur : cur + 1'b1;
        else    nxt = (cur == '0)  ? cur : cur - 1'b1;
    end
endmodule

// File: rtl/wiper_src_mux.sv
// Picks the single load source for this cycle and forms the next position.
// Ranking: recall, direct write, bank transfer, step. Bank is flattened.
module wiper_src_mux #(
    parameter int W = 6,
    parameter int N = 4
) (
    input  logic             recall,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_val,
    input  logic             xfer_en,
    input  logic [$clog2(N)-1:0] xfer_sel,
    input  logic             step_en,
    input  logic [W-1:0]     step_val,
    input  logic [N*W-1:0]   bank,
    input  logic [W-1:0]     cur,
    output wiper_pkg::src_e  src,
    output logic [W-1:0]     nxt
);
    import wiper_pkg::*;

    logic [W-1:0] entry [N];

    // Split the flattened bank into entries.
    for (genvar i = 0; i < N; i++) begin : g_split
        assign entry[i] = bank[i*W +: W];
    end

    // Rank the requests; the first active one wins.
    always_comb begin
        if      (recall)  src = SRC_RECALL;
        else if (wr_en)   src = SRC_WRITE;
        else if (xfer_en) src = SRC_XFER;
        else if (step_en) src = SRC_STEP;
        else              src = SRC_NONE;
    end

    // Form the next position from the chosen source.
    always_comb begin
        case (src)
            SRC_RECALL: nxt = entry[0];
            SRC_WRITE:  nxt = wr_val;
            SRC_XFER:   nxt = entry[xfer_sel];
            SRC_STEP:   nxt = step_val;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/tap_decoder.sv
// Binary to one-hot decoder for the tap switch enables.
// Assumes T equals 2**W, so every code maps to one tap.
module tap_decoder #(
    parameter int W = 6,
    parameter int T = 64
) (
    input  logic [W-1:0] code,
    output logic [T-1:0] onehot
);
    // One comparator per tap.
    for (genvar k = 0; k < T; k++) begin : g_tap
        assign onehot[k] = (code == W'(k));
    end
endmodule

// File: rtl/wiper_tap_ctrl.sv
// Wiper position register with a registered one-hot tap enable.
// Position and enables update at the same edge from the selected source.
// Assumes recall is pulsed by the system once stored data is valid.
module wiper_tap_ctrl (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        recall,
    input  logic        wr_en,
    input  logic [5:0]  wr_val,
    input  logic        xfer_en,
    input  logic [1:0]  xfer_sel,
    input  logic        step_en,
    input  logic        step_up,
    input  logic [23:0] reg_bank,
    output logic [5:0]  pos,
    output logic [63:0] tap_en
);
    import wiper_pkg::*;

    localparam logic [POS_W-1:0] TOP = {POS_W{1'b1}};

    logic [POS_W-1:0] step_val;
    logic [POS_W-1:0] nxt_pos;
    logic [TAPS-1:0]  nxt_tap;
    src_e             src;

    wiper_stepper #(.W(POS_W)) u_step (
        .cur (pos),
        .up  (step_up),
        .nxt (step_val)
    );

    wiper_src_mux #(.W(POS_W), .N(NUM_REGS)) u_mux (
        .recall   (recall),
        .wr_en    (wr_en),
        .wr_val   (wr_val),
        .xfer_en  (xfer_en),
        .xfer_sel (xfer_sel),
        .step_en  (step_en),
        .step_val (step_val),
        .bank     (reg_bank),
        .cur      (pos),
        .src      (src),
        .nxt      (nxt_pos)
    );

    tap_decoder #(.W(POS_W), .T(TAPS)) u_dec (
        .code   (nxt_pos),
        .onehot (nxt_tap)
    );

    // Register the position and its decoded enables together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos    <= '0;
            tap_en <= TAPS'(1);
        end else begin
            pos    <= nxt_pos;
            tap_en <= nxt_tap;
        end
    end

    AST_ONE_TAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot(tap_en)) else $error("one tap"); // R2
    AST_TAP_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> tap_en[pos]) else $error("tap index"); // R2
    AST_RECALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        recall |=> pos == $past(reg_bank[5:0])) else $error("recall"); // R8
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && wr_en) |=> pos == $past(wr_val)) else $error("write"); // R3
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !wr_en && !xfer_en && step_en && step_up && pos == TOP)
        |=> pos == TOP) else $error("sat top"); // R7
    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !wr_en && !xfer_en && step_en && !step_up && pos == '0)
        |=> pos == '0) else $error("sat bottom"); // R7
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!recall && !wr_en && !xfer_en && !step_en) |=> $stable(pos)) else $error("hold"); // R10
endmodule

// File: tb/wiper_tap_ctrl_tb.sv
module wiper_tap_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        recall = 1'b0, wr_en = 1'b0, xfer_en = 1'b0, step_en = 1'b0, step_up = 1'b0;
    logic [5:0]  wr_val = '0;
    logic [1:0]  xfer_sel = '0;
    logic [23:0] reg_bank = {6'd50, 6'd33, 6'd17, 6'd9};
    logic [5:0]  pos;
    logic [63:0] tap_en;
    int checks = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    wiper_tap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .recall(recall), .wr_en(wr_en), .wr_val(wr_val),
        .xfer_en(xfer_en), .xfer_sel(xfer_sel), .step_en(step_en), .step_up(step_up),
        .reg_bank(reg_bank), .pos(pos), .tap_en(tap_en)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        checks++;
        if (pos !== exp || tap_en !== (64'h1 << exp)) begin
            bad++;
            $display("FAIL %s pos=%0d tap=%h expected pos=%0d tap=%h",
                     req, pos, tap_en, exp, 64'h1 << exp);
        end
    endtask

    task automatic idle_all();
        recall = 0; wr_en = 0; xfer_en = 0; step_en = 0;
    endtask

    // One cycle with the given strobes, then sample after the edge.
    task automatic cyc(input logic rc, input logic we, input logic [5:0] wv,
                       input logic xe, input logic [1:0] xs,
                       input logic se, input logic su);
        @(negedge clk);
        recall = rc; wr_en = we; wr_val = wv; xfer_en = xe; xfer_sel = xs;
        step_en = se; step_up = su;
        @(negedge clk);
        idle_all();
    endtask

    task automatic t_reset();
        rst_n = 0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R1", 6'd0);
        rst_n = 1;
    endtask

    task automatic t_write();
        cyc(0, 1, 6'd21, 0, 0, 0, 0); chk("R3", 6'd21);
        cyc(0, 1, 6'd63, 0, 0, 0, 0); chk("R3 R2 high end", 6'd63);
        cyc(0, 1, 6'd0, 0, 0, 0, 0);  chk("R3 R2 low end", 6'd0);
    endtask

    task automatic t_xfer();
        cyc(0, 0, 0, 1, 2'd1, 0, 0); chk("R4 sel1", 6'd17);
        cyc(0, 0, 0, 1, 2'd3, 0, 0); chk("R4 sel3", 6'd50);
        cyc(0, 0, 0, 1, 2'd2, 0, 0); chk("R4 sel2", 6'd33);
    endtask

    task automatic t_step();
        cyc(0, 1, 6'd30, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R5", 6'd31);
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R5", 6'd32);
        cyc(0, 0, 0, 0, 0, 1, 0); chk("R6", 6'd31);
        cyc(0, 0, 0, 0, 0, 1, 0); chk("R6", 6'd30);
    endtask

    task automatic t_sat();
        cyc(0, 1, 6'd62, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R5 to top", 6'd63);
        cyc(0, 0, 0, 0, 0, 1, 1); chk("R7 top", 6'd63);
        cyc(0, 1, 6'd1, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 1, 0); chk("R6 to bottom", 6'd0);
        cyc(0, 0, 0, 0, 0, 1, 0); chk("R7 bottom", 6'd0);
    endtask

    task automatic t_recall();
        cyc(0, 1, 6'd40, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 0, 0); chk("R8 alone", 6'd9);
        cyc(1, 1, 6'd44, 0, 0, 0, 0); chk("R8 over write", 6'd9);
        cyc(1, 0, 0, 1, 2'd3, 1, 1); chk("R8 over xfer+step", 6'd9);
    endtask

    task automatic t_priority();
        cyc(0, 1, 6'd12, 0, 0, 1, 1); chk("R9 write over step", 6'd12);
        cyc(0, 1, 6'd5, 1, 2'd3, 0, 0); chk("R9 write over xfer", 6'd5);
        cyc(0, 0, 0, 1, 2'd2, 1, 0); chk("R9 xfer over step", 6'd33);
    endtask

    task automatic t_hold();
        cyc(0, 0, 6'd7, 0, 2'd1, 0, 1); chk("R10", 6'd33);
        reg_bank = {6'd1, 6'd2, 6'd3, 6'd4};
        cyc(0, 0, 0, 0, 0, 0, 0); chk("R10 bank change", 6'd33);
    endtask

    initial begin
        t_reset();
        t_write();
        t_xfer();
        t_step();
        t_sat();
        t_recall();
        t_priority();
        t_hold();
        finished = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule